// File: doc/BRIEF.md
# Nibble Load Execution Unit

This block executes the 4-bit load instructions of a small nibble-wide microcontroller core. Every cycle it may receive one 13-bit instruction word with a valid strobe. It decodes the word and finishes the load in that same cycle. It holds the A and B nibble registers and the four-bit flag register F. It reads the 16-bit X and Y index registers as inputs, and it drives a data-memory read port with a combinational address.

A separate extension command latches an 8-bit operand and raises the E flag. While E is set, an indirect load does not use the full index register. It reads from a fixed page instead: page 00H for the X form and page FFH for the Y form, with the latched byte as the low address byte. Immediate loads do not use extended addressing. The next legal instruction consumes the extension.

Top module: `nib_load_unit`

## Requirements
- R1: A valid code 0x1EC0+n loads n (the low nibble) into A, and a valid code 0x1ED0+n loads n into B, at the clock edge that ends the instruction cycle.
- R2: A valid code 0x10B0+n writes n to F. The flag order is {E,I,C,Z} with E as bit 3, so n[3] sets or clears E. Because E is also the pending-extension flag, a set E then arms extension with the byte held at that time.
- R3: Immediate loads into A or B and all indirect loads clear E and leave I, C and Z unchanged.
- R4: Valid codes 0x1EE0, 0x1EE2, 0x1EE4 and 0x1EE6 are indirect loads. Instruction bit 1 selects Y over X and bit 2 selects B over A. In that cycle mem_rd_o is high and mem_addr_o shows the index register. mem_data_i is written to the destination at the closing edge.
- R5: ext_cmd_i latches ext_byte_i and sets E. While E is set, the X form of an indirect load reads address 0x0000+byte and the Y form reads 0xFF00+byte.
- R6: Immediate loads write their immediate whether or not E is set, and they issue no memory read.
- R7: A valid code outside the listed set drives illegal_o high in that cycle. It asserts no read and leaves A, B, F (including E) and the extension byte unchanged.
- R8: If ext_cmd_i coincides with a valid instruction, the instruction uses the extension state held before that edge. After the edge E is 1 and the new byte is held, even when the instruction is a load into F.
- R9: After reset A, B, F and the extension byte are zero. With no valid and no extension command, nothing changes, mem_rd_o is low and illegal_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word valid this cycle |
| instr_i | input | 13 | Instruction word |
| ext_cmd_i | input | 1 | Extension command strobe |
| ext_byte_i | input | 8 | Extension operand |
| idx_x_i | input | 16 | X index register |
| idx_y_i | input | 16 | Y index register |
| mem_rd_o | output | 1 | Data-memory read request |
| mem_addr_o | output | 16 | Data-memory read address |
| mem_data_i | input | 4 | Data-memory read data |
| reg_a_o | output | 4 | A register |
| reg_b_o | output | 4 | B register |
| flags_o | output | 4 | Flags {E,I,C,Z} |
| illegal_o | output | 1 | Unrecognised valid code |

## Verification
Two things can happen in one cycle: an extension command, and an instruction that consumes or overwrites E. The bench drives ext_cmd_i together with an indirect load, together with a load into F, and together with an illegal code. The reference model judges the read address against the extension state before the edge, and judges E and the byte after the edge. Randomised streams mix these overlaps with back-to-back extensions and idle cycles, and every output is compared with the model on every clock.

// File: rtl/nl_pkg.sv
package nl_pkg;
  localparam int IW = 13;
  localparam int DW = 4;
  localparam logic [IW-1:0] CODE_IMM_A = 13'h1EC0;
  localparam logic [IW-1:0] CODE_IMM_B = 13'h1ED0;
  localparam logic [IW-1:0] CODE_IMM_F = 13'h10B0;
  localparam logic [IW-1:0] CODE_IND   = 13'h1EE0;
  localparam int FLAG_E = 3;

  typedef enum logic [2:0] {
    OP_NONE, OP_ILL, OP_IMM_A, OP_IMM_B, OP_IMM_F, OP_IND
  } op_e;

  typedef struct packed {
    op_e           op;
    logic          dst_b;
    logic          use_y;
    logic [DW-1:0] imm;
  } dec_t;
endpackage

// File: rtl/nl_decode.sv
module nl_decode
  import nl_pkg::*;
(
  input  logic          valid_i,
  input  logic [IW-1:0] instr_i,
  output dec_t          dec_o
);
  always_comb begin
    dec_o.op    = OP_NONE;
    dec_o.imm   = instr_i[DW-1:0];
    dec_o.use_y = instr_i[1];
    dec_o.dst_b = instr_i[2];
    if (valid_i) begin
      if (instr_i[IW-1:DW] == CODE_IMM_A[IW-1:DW])      dec_o.op = OP_IMM_A;
      else if (instr_i[IW-1:DW] == CODE_IMM_B[IW-1:DW]) dec_o.op = OP_IMM_B;
      else if (instr_i[IW-1:DW] == CODE_IMM_F[IW-1:DW]) dec_o.op = OP_IMM_F;
      else if (instr_i[IW-1:3] == CODE_IND[IW-1:3] && !instr_i[0]) dec_o.op = OP_IND;
      else dec_o.op = OP_ILL;
    end
  end
endmodule

// File: rtl/nl_addr_gen.sv
module nl_addr_gen #(
  parameter int AW = 16,
  parameter int EW = 8
) (
  input  logic          use_y_i,
  input  logic          ext_on_i,
  input  logic [EW-1:0] ext_byte_i,
  input  logic [AW-1:0] idx_x_i,
  input  logic [AW-1:0] idx_y_i,
  output logic [AW-1:0] addr_o
);
  localparam int PW = AW - EW;
  localparam logic [PW-1:0] PAGE_X = '0;
  localparam logic [PW-1:0] PAGE_Y = '1;

  always_comb begin
    if (ext_on_i) addr_o = {use_y_i ? PAGE_Y : PAGE_X, ext_byte_i};
    else          addr_o = use_y_i ? idx_y_i : idx_x_i;
  end
endmodule

// File: rtl/nl_regs.sv
module nl_regs
  import nl_pkg::*;
#(
  parameter int EW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  dec_t          dec_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic          ext_cmd_i,
  input  logic [EW-1:0] ext_byte_i,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o,
  output logic [DW-1:0] f_o,
  output logic [EW-1:0] ext_byte_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_o <= '0;
      b_o <= '0;
      f_o <= '0;
      ext_byte_o <= '0;
    end else begin
      unique case (dec_i.op)
        OP_IMM_A: begin a_o <= dec_i.imm; f_o[FLAG_E] <= 1'b0; end
        OP_IMM_B: begin b_o <= dec_i.imm; f_o[FLAG_E] <= 1'b0; end
        OP_IMM_F: f_o <= dec_i.imm;
        OP_IND: begin
          if (dec_i.dst_b) b_o <= rd_data_i;
          else             a_o <= rd_data_i;
          f_o[FLAG_E] <= 1'b0;
        end
        default: ;
      endcase
      // extension command overrides the instruction's E update
      if (ext_cmd_i) begin
        f_o[FLAG_E] <= 1'b1;
        ext_byte_o  <= ext_byte_i;
      end
    end
  end

  p_ext_arm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_cmd_i |=> f_o[FLAG_E] && ext_byte_o == $past(ext_byte_i));
  p_byte_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_cmd_i |=> $stable(ext_byte_o));
endmodule

// File: rtl/nib_load_unit.sv
module nib_load_unit
  import nl_pkg::*;
#(
  parameter int AW = 16,
  parameter int EW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          instr_valid_i,
  input  logic [12:0]   instr_i,
  input  logic          ext_cmd_i,
  input  logic [EW-1:0] ext_byte_i,
  input  logic [AW-1:0] idx_x_i,
  input  logic [AW-1:0] idx_y_i,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [3:0]    mem_data_i,
  output logic [3:0]    reg_a_o,
  output logic [3:0]    reg_b_o,
  output logic [3:0]    flags_o,
  output logic          illegal_o
);
  dec_t          dec;
  logic [EW-1:0] ext_byte_q;

  nl_decode u_dec (
    .valid_i (instr_valid_i),
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  nl_addr_gen #(.AW(AW), .EW(EW)) u_agen (
    .use_y_i    (dec.use_y),
    .ext_on_i   (flags_o[FLAG_E]),
    .ext_byte_i (ext_byte_q),
    .idx_x_i    (idx_x_i),
    .idx_y_i    (idx_y_i),
    .addr_o     (mem_addr_o)
  );

  nl_regs #(.EW(EW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dec_i      (dec),
    .rd_data_i  (mem_data_i),
    .ext_cmd_i  (ext_cmd_i),
    .ext_byte_i (ext_byte_i),
    .a_o        (reg_a_o),
    .b_o        (reg_b_o),
    .f_o        (flags_o),
    .ext_byte_o (ext_byte_q)
  );

  assign mem_rd_o  = (dec.op == OP_IND);
  assign illegal_o = (dec.op == OP_ILL);

  p_illegal_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o && !ext_cmd_i |=> $stable(reg_a_o) && $stable(reg_b_o) && $stable(flags_o));
  p_illegal_no_rd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(illegal_o && mem_rd_o));
  p_page_x_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o && flags_o[FLAG_E] && !instr_i[1] |-> mem_addr_o[AW-1:EW] == '0);
  p_page_y_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o && flags_o[FLAG_E] && instr_i[1] |-> mem_addr_o[AW-1:EW] == '1);
  p_ind_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> (instr_i[2] ? reg_b_o : reg_a_o) == $past(mem_data_i) || $past(instr_i[2]) != instr_i[2]);
  p_clear_e_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && !illegal_o && instr_i[12:4] != CODE_IMM_F[12:4] && !ext_cmd_i
      |=> !flags_o[FLAG_E]);
  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i && !ext_cmd_i |=> $stable(reg_a_o) && $stable(reg_b_o) && $stable(flags_o));
endmodule

// File: tb/nib_load_unit_tb.sv
module nib_load_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [12:0] instr = '0;
  logic        ext = 1'b0;
  logic [7:0]  ext_b = '0;
  logic [15:0] x = '0, y = '0;
  logic [3:0]  md = '0;
  logic        rd, ill;
  logic [15:0] addr;
  logic [3:0]  ra, rb, fl;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [3:0] m_a = '0, m_b = '0, m_f = '0;
  logic [7:0] m_byte = '0;

  always #4 clk = ~clk;

  nib_load_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid), .instr_i(instr),
    .ext_cmd_i(ext), .ext_byte_i(ext_b), .idx_x_i(x), .idx_y_i(y),
    .mem_rd_o(rd), .mem_addr_o(addr), .mem_data_i(md),
    .reg_a_o(ra), .reg_b_o(rb), .flags_o(fl), .illegal_o(ill)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one instruction cycle: drive after negedge, check comb, then registers
  task automatic step(bit v, logic [12:0] code, bit e, logic [7:0] eb,
                      logic [15:0] xv, logic [15:0] yv, logic [3:0] d);
    int kind; // 0 none 1 A 2 B 3 F 4 ind 5 illegal
    logic exp_rd;
    logic [15:0] exp_addr;
    valid = v; instr = code; ext = e; ext_b = eb; x = xv; y = yv; md = d;
    kind = 0;
    if (v) begin
      if (code[12:4] == 9'h1EC) kind = 1;
      else if (code[12:4] == 9'h1ED) kind = 2;
      else if (code[12:4] == 9'h10B) kind = 3;
      else if (code == 13'h1EE0 || code == 13'h1EE2 || code == 13'h1EE4 || code == 13'h1EE6) kind = 4;
      else kind = 5;
    end
    exp_rd = (kind == 4);
    if (m_f[3]) exp_addr = code[1] ? {8'hFF, m_byte} : {8'h00, m_byte};
    else exp_addr = code[1] ? yv : xv;
    #2;
    chk("R4 mem_rd_o", {15'd0, rd}, {15'd0, exp_rd});
    if (exp_rd) chk(m_f[3] ? "R5 ext addr" : "R4 idx addr", addr, exp_addr);
    chk("R7 illegal_o", {15'd0, ill}, {15'd0, kind == 5});
    @(posedge clk);
    case (kind)
      1: begin m_a = code[3:0]; m_f[3] = 1'b0; end
      2: begin m_b = code[3:0]; m_f[3] = 1'b0; end
      3: m_f = code[3:0];
      4: begin if (code[2]) m_b = d; else m_a = d; m_f[3] = 1'b0; end
      default: ;
    endcase
    if (e) begin m_f[3] = 1'b1; m_byte = eb; end
    @(negedge clk);
    chk(kind == 4 ? "R4 reg A" : "R1 reg A", {12'd0, ra}, {12'd0, m_a});
    chk(kind == 4 ? "R4 reg B" : "R1 reg B", {12'd0, rb}, {12'd0, m_b});
    chk(e ? "R8 flags" : (kind == 3 ? "R2 flags" : "R3 flags"), {12'd0, fl}, {12'd0, m_f});
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset A", {12'd0, ra}, 16'd0);
    chk("R9 reset B", {12'd0, rb}, 16'd0);
    chk("R9 reset F", {12'd0, fl}, 16'd0);
    // R9 idle
    step(0, 13'h1EE0, 0, 8'h00, 16'h1234, 16'h5678, 4'h9);
    // R1 immediates
    step(1, 13'h1EC5, 0, 8'h00, 16'h0, 16'h0, 4'h0);
    step(1, 13'h1EDA, 0, 8'h00, 16'h0, 16'h0, 4'h0);
    // R2 load F, E clear
    step(1, 13'h10B6, 0, 8'h00, 16'h0, 16'h0, 4'h0);
    // R4 plain indirect, all four forms
    step(1, 13'h1EE0, 0, 8'h00, 16'hA1B2, 16'hC3D4, 4'h3);
    step(1, 13'h1EE2, 0, 8'h00, 16'hA1B2, 16'hC3D4, 4'h4);
    step(1, 13'h1EE4, 0, 8'h00, 16'hA1B2, 16'hC3D4, 4'h7);
    step(1, 13'h1EE6, 0, 8'h00, 16'hA1B2, 16'hC3D4, 4'hE);
    // R5 extension, X page then Y page
    step(0, 13'h0000, 1, 8'h3C, 16'h0, 16'h0, 4'h0);
    step(1, 13'h1EE0, 0, 8'h00, 16'h4444, 16'h5555, 4'h1);
    step(0, 13'h0000, 1, 8'h81, 16'h0, 16'h0, 4'h0);
    step(1, 13'h1EE6, 0, 8'h00, 16'h4444, 16'h5555, 4'h2);
    // R3 E cleared by indirect: next read uses index again
    step(1, 13'h1EE2, 0, 8'h00, 16'h4444, 16'h5555, 4'h8);
    // R2 LD F with E=1 arms extension with held byte
    step(1, 13'h10BF, 0, 8'h00, 16'h0, 16'h0, 4'h0);
    step(1, 13'h1EE4, 0, 8'h00, 16'h9999, 16'h8888, 4'h5);
    // R6 immediate ignores extension
    step(0, 13'h0000, 1, 8'h55, 16'h0, 16'h0, 4'h0);
    step(1, 13'h1EC9, 0, 8'h00, 16'h0, 16'h0, 4'h0);
    // R7 illegal keeps pending extension
    step(0, 13'h0000, 1, 8'h77, 16'h0, 16'h0, 4'h0);
    step(1, 13'h1EE8, 0, 8'h00, 16'h0, 16'h0, 4'h0);
    step(1, 13'h1EE1, 0, 8'h00, 16'h0, 16'h0, 4'h0);
    step(1, 13'h0000, 0, 8'h00, 16'h0, 16'h0, 4'h0);
    step(1, 13'h1EE2, 0, 8'h00, 16'h1111, 16'h2222, 4'hB);
    // R8 overlap: ext with indirect, with LD F, with illegal
    step(0, 13'h0000, 1, 8'h10, 16'h0, 16'h0, 4'h0);
    step(1, 13'h1EE0, 1, 8'h20, 16'h1111, 16'h2222, 4'hC);
    step(1, 13'h10B0, 1, 8'h30, 16'h0, 16'h0, 4'h0);
    step(1, 13'h1EE6, 0, 8'h00, 16'h1111, 16'h2222, 4'hD);
    step(1, 13'h1FFF, 1, 8'h40, 16'h0, 16'h0, 4'h0);
    step(1, 13'h1EE2, 0, 8'h00, 16'h1111, 16'h2222, 4'h6);
    // randomised mix
    for (int i = 0; i < 400; i++) begin
      logic [12:0] c;
      int sel;
      sel = $urandom_range(0, 5);
      case (sel)
        0: c = 13'h1EC0 | 13'($urandom_range(0, 15));
        1: c = 13'h1ED0 | 13'($urandom_range(0, 15));
        2: c = 13'h10B0 | 13'($urandom_range(0, 15));
        3, 4: c = 13'h1EE0 | 13'($urandom_range(0, 3) * 2);
        default: c = 13'($urandom());
      endcase
      step($urandom_range(0, 4) != 0, c, $urandom_range(0, 3) == 0, 8'($urandom()),
           16'($urandom()), 16'($urandom()), 4'($urandom()));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule